// File: doc/BRIEF.md
# Counter Overflow Request Enable Unit

This unit watches overflow pulses from three event counters and one cycle counter and turns them into two requests for the rest of the chip. One is an active-low system reset request and the other is an active-high debug request. Each request has its own enable register, which selects the counter sources that may raise it.

Every enable register is reached through two addresses. A write of ones at the set address turns the matching bits on. A write of ones at the clear address turns them off. A read at either address returns the current enables. Every overflow pulse is caught in a sticky status flag, which is cleared by writing ones to the status address. A request stays asserted as long as any source has both its enable and its flag set. Both outputs come from registers, so a request appears on the clock edge that follows the pulse or the write that completes the condition.

In each 32-bit word, the cycle-counter source sits at bit 31 and event counters 2, 1 and 0 sit at bits 2, 1 and 0. The bits in between are not used. The word addresses are 0 for reset-enable set, 1 for reset-enable clear, 2 for debug-enable set, 3 for debug-enable clear and 4 for status. Addresses 5 to 7 are unmapped.

Top module: `ovf_req_unit`

## Requirements
- R1: After reset, both enable registers and the status flags read zero, `rst_req_n` is 1 and `dbg_req` is 0.
- R2: A write to a set address (0 or 2) sets each enable bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R3: A write to a clear address (1 or 3) clears each enable bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A read at the set address and a read at the clear address of the same register return the same current enable value.
- R5: Bits 30 to 3 of every readable word read as 0, and writes to those bits have no effect.
- R6: An overflow pulse on event counter i sets status bit i, and a pulse on the cycle counter sets status bit 31. The flag stays set until it is cleared, whether or not the source is enabled.
- R7: A write to the status address (4) clears each flag whose data bit is 1. A pulse in the same cycle as that write leaves the flag set.
- R8: `rst_req_n` is 0 in the cycle after any source has both its reset enable and its flag set, whether the flag or the enable was the last to arrive.
- R9: `dbg_req` is 1 in the cycle after any source has both its debug enable and its flag set.
- R10: A request is withdrawn in the cycle after the last enabled flag is cleared or its enable is cleared.
- R11: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovf_evt | input | 3 | Overflow pulses of event counters 2..0 |
| ovf_cyc | input | 1 | Overflow pulse of the cycle counter |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req_n | output | 1 | Reset request, active low |
| dbg_req | output | 1 | Debug request, active high |

## Verification
The assertions check several rules on every cycle:
- the unused read bits are zero;
- every overflow pulse leaves its flag set;
- a write at a clear address drops its bits;
- an enabled source that overflows drives the matching request in the following cycle.

Some behaviour can only be shown by the bench's scenarios, which read values back through the bus and watch the outputs:
- that a zero write leaves bits as they were;
- that the set and clear addresses read back alike;
- that a pulse wins over a clear arriving in the same cycle;
- that a request is withdrawn once its last enabled flag or enable is gone;
- that unmapped addresses have no effect.

// File: rtl/ovf_req_unit.sv
module ovf_req_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int EVT_N  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  ovf_evt,
  input  logic              ovf_cyc,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req_n,
  output logic              dbg_req
);
  localparam int PAD_W = DATA_W - 1 - EVT_N;
  localparam logic [DATA_W-1:0] MASK = {1'b1, {PAD_W{1'b0}}, {EVT_N{1'b1}}};
  localparam logic [ADDR_W-1:0] A_RST_SET = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RST_CLR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DBG_SET = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DBG_CLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STS     = ADDR_W'(4);

  logic [DATA_W-1:0] rst_en_q, dbg_en_q, sts_q;
  logic [DATA_W-1:0] rst_en_d, dbg_en_d, sts_d;
  logic [DATA_W-1:0] src_v, wmask;

  assign src_v = {ovf_cyc, {PAD_W{1'b0}}, ovf_evt};
  assign wmask = bus_wdata & MASK;

  always_comb begin
    rst_en_d = rst_en_q;
    dbg_en_d = dbg_en_q;
    sts_d    = sts_q;
    if (bus_wr) begin
      case (bus_addr)
        A_RST_SET: rst_en_d = rst_en_q | wmask;
        A_RST_CLR: rst_en_d = rst_en_q & ~wmask;
        A_DBG_SET: dbg_en_d = dbg_en_q | wmask;
        A_DBG_CLR: dbg_en_d = dbg_en_q & ~wmask;
        A_STS:     sts_d    = sts_q & ~wmask;
        default: ;
      endcase
    end
    sts_d = sts_d | src_v;
  end

  always_comb begin
    case (bus_addr)
      A_RST_SET, A_RST_CLR: bus_rdata = rst_en_q;
      A_DBG_SET, A_DBG_CLR: bus_rdata = dbg_en_q;
      A_STS:                bus_rdata = sts_q;
      default:              bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en_q  <= '0;
      dbg_en_q  <= '0;
      sts_q     <= '0;
      rst_req_n <= 1'b1;
      dbg_req   <= 1'b0;
    end else begin
      rst_en_q  <= rst_en_d;
      dbg_en_q  <= dbg_en_d;
      sts_q     <= sts_d;
      rst_req_n <= ~|(rst_en_d & sts_d);
      dbg_req   <= |(dbg_en_d & sts_d);
    end
  end
endmodule

module ovf_req_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int EVT_N  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_N-1:0]  ovf_evt,
  input logic              ovf_cyc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] rst_en_q,
  input logic [DATA_W-1:0] dbg_en_q,
  input logic [DATA_W-1:0] sts_q,
  input logic              rst_req_n,
  input logic              dbg_req
);
  localparam logic [ADDR_W-1:0] A_RST_CLR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DBG_CLR = ADDR_W'(3);

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-2:EVT_N] == '0);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_cyc |=> sts_q[DATA_W-1]);

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RST_CLR && bus_wdata[0]) |=> !rst_en_q[0]);

  assert_rst_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_cyc && rst_en_q[DATA_W-1] &&
     !(bus_wr && bus_addr == A_RST_CLR && bus_wdata[DATA_W-1])) |=> !rst_req_n);

  assert_dbg_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt[0] && dbg_en_q[0] &&
     !(bus_wr && bus_addr == A_DBG_CLR && bus_wdata[0])) |=> dbg_req);
endmodule

bind ovf_req_unit ovf_req_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_N(EVT_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .ovf_cyc(ovf_cyc),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rst_en_q(rst_en_q), .dbg_en_q(dbg_en_q), .sts_q(sts_q),
  .rst_req_n(rst_req_n), .dbg_req(dbg_req)
);

// File: tb/ovf_req_unit_tb.sv
module ovf_req_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ovf_evt = '0;
  logic        ovf_cyc = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req_n, dbg_req;

  always #2.5 clk = ~clk;

  ovf_req_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .ovf_cyc(ovf_cyc),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req_n(rst_req_n), .dbg_req(dbg_req)
  );

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_out ? {30'd0, rst_req_n, dbg_req} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic exp_read(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_out = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    step();
  endtask

  task automatic exp_out(input bit rn, input bit dr, input string tag);
    item_t it;
    it.is_out = 1'b1; it.exp = {30'd0, rn, dr}; it.tag = tag;
    sb_q.push_back(it);
    step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit cyc = 0);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; ovf_cyc = cyc;
    step();
    bus_wr = 1'b0; ovf_cyc = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] e, input bit cyc);
    ovf_evt = e; ovf_cyc = cyc;
    step();
    ovf_evt = '0; ovf_cyc = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    exp_out(1, 0, "R1 idle outputs");
    for (int a = 0; a < 5; a++) exp_read(3'(a), 32'h0, "R1 reset value");

    wr(3'd0, 32'h8000_0005);
    exp_read(3'd0, 32'h8000_0005, "R2 set bits");
    wr(3'd0, 32'h0000_0002);
    exp_read(3'd0, 32'h8000_0007, "R2 zero keeps bits");
    exp_read(3'd1, 32'h8000_0007, "R4 clear addr readback");

    wr(3'd2, 32'hFFFF_FFFF);
    exp_read(3'd2, 32'h8000_0007, "R5 reserved ignored");
    exp_read(3'd3, 32'h8000_0007, "R4 dbg clear addr readback");
    wr(3'd3, 32'h0000_0006);
    exp_read(3'd2, 32'h8000_0001, "R3 clear bits");
    wr(3'd3, 32'h0000_0000);
    exp_read(3'd3, 32'h8000_0001, "R3 zero keeps bits");

    wr(3'd5, 32'hFFFF_FFFF);
    exp_read(3'd5, 32'h0, "R11 unmapped reads zero");
    exp_read(3'd0, 32'h8000_0007, "R11 no effect on rst enable");
    exp_read(3'd4, 32'h0, "R11 no effect on status");

    wr(3'd1, 32'hFFFF_FFFF);
    exp_read(3'd0, 32'h0, "R3 clear all");
    pulse(3'b010, 0);
    exp_read(3'd4, 32'h0000_0002, "R6 flag latched while disabled");
    exp_out(1, 0, "R8 no request when disabled");

    wr(3'd0, 32'h0000_0002);
    exp_out(0, 0, "R8 request after enabling write");

    pulse(3'b000, 1);
    exp_out(0, 1, "R9 debug request on cycle overflow");
    exp_read(3'd4, 32'h8000_0002, "R6 both flags set");

    wr(3'd4, 32'h0000_0002);
    exp_out(1, 1, "R10 reset request withdrawn");
    exp_read(3'd4, 32'h8000_0000, "R7 W1C status");

    wr(3'd4, 32'h8000_0000, 1);
    exp_read(3'd4, 32'h8000_0000, "R7 pulse beats clear");
    exp_out(1, 1, "R9 debug still held");

    wr(3'd3, 32'h8000_0000);
    exp_out(1, 0, "R10 debug withdrawn by enable clear");

    pulse(3'b001, 0);
    exp_out(1, 1, "R9 debug on event 0");
    exp_read(3'd4, 32'h8000_0001, "R6 event 0 flag");
    wr(3'd4, 32'hFFFF_FFFF);
    exp_out(1, 0, "R10 debug withdrawn by status clear");
    exp_read(3'd4, 32'h0, "R7 all flags cleared");

    step();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule